// File: doc/BRIEF.md
# Trimmed Real-Time Clock Counter

This block keeps wall-clock time in whole seconds. It counts pulses from a nominal 32.768 kHz oscillator, which arrive as a one-cycle enable on the system clock. Each time a full second of pulses has been seen, it advances a 32-bit seconds counter. A crystal is rarely exact, so a trim value sets the number of pulses per second. A fractional part of the trim stretches a chosen number of seconds in every 1023-second window by one extra pulse. After trim, the residual error is at most one oscillator cycle per window, which is about 0.03 ppm.

Software reaches four word registers over a simple single-cycle bus: an alarm value, the seconds count, the trim setting and a status word. The status word holds an alarm flag and a once-per-second flag, each cleared by writing 1, together with an enable bit for each. A single interrupt line reports the flags.

Top module: `rtc_core`

## Requirements
- R1: After a synchronous active-low reset, the register values are as follows. Count reads 0, alarm reads 0, trim reads 0x00007FFF (integer 32767, fraction 0), status reads 0, and irq is low.
- R2: The divider counts only cycles where osc_tick is high. With fraction 0, each second lasts trim integer + 1 such cycles, and the count rises by exactly 1 at its end.
- R3: A 10-bit window counter counts seconds from 0 to 1022 and then wraps to 0. A second whose window index is below the trim fraction lasts one extra osc_tick cycle.
- R4: While osc_tick is low, the count, the divider and the flags do not advance.
- R5: A write to the count register loads the written value and restarts the divider, so the next increment comes one full second later. A write that lands on a second boundary wins, and that boundary does not increment the count.
- R6: Register byte offsets are: alarm 0x00, count 0x04, trim 0x08, status 0x10. The trim integer is in bits [15:0] and the fraction in bits [25:16]. Any other offset reads 0.
- R7: Alarm flag (status bit 0) sets on the boundary that makes the count equal to the alarm register, only when the alarm enable (status bit 2) is 1.
- R8: The tick flag (status bit 1) sets on every second boundary.
- R9: Writing 1 to status bit 0 or bit 1 clears that flag, and writing 0 leaves it unchanged. If a set and a clear fall in the same cycle, the flag ends up set.
- R10: irq is high when the alarm flag is set, or when the tick flag and the tick enable (status bit 3) are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_tick | input | 1 | One-cycle pulse per oscillator cycle |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt request |

## Verification
Two things can land in the same cycle: a second boundary that sets a flag, and a software write to the status register that clears that flag. The bench counts edges from a count write under a short trim. It issues the write-1 clear on exactly the edge where the count reaches the alarm value. It then judges that the alarm flag reads 1 and that irq is high. The same edge counting puts a count write on a second boundary, and the bench expects the written value without an increment.

// File: rtl/rtc_pkg.sv
// Shared constants for the real-time clock: bus geometry and register offsets.
// Assumes byte offsets on a word-aligned bus.
package rtc_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 32;
    localparam logic [ADDR_W-1:0] OFF_ALARM = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_COUNT = 5'h04;
    localparam logic [ADDR_W-1:0] OFF_TRIM  = 5'h08;
    localparam logic [ADDR_W-1:0] OFF_STAT  = 5'h10;
    // status bit positions
    localparam int ST_ALM_FLAG = 0;
    localparam int ST_TCK_FLAG = 1;
    localparam int ST_ALM_EN   = 2;
    localparam int ST_TCK_EN   = 3;
endpackage

// File: rtl/rtc_prescaler.sv
// Trimmed second divider. Counts osc_tick pulses and emits sec_tick at the end
// of each second. A second is div_last+1 pulses long, plus one pulse while the
// window index is below frac. The window index runs 0..WIN_LEN-1.
// Assumes restart is a single-cycle pulse that overrides a boundary.
module rtc_prescaler #(
    parameter int DIV_W   = 16,
    parameter int WIN_W   = 10,
    parameter int WIN_LEN = 1023
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_tick,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_last,
    input  logic [WIN_W-1:0] frac,
    output logic             sec_tick
);
    localparam int PW = DIV_W + 1;
    localparam logic [WIN_W-1:0] WIN_END = WIN_W'(WIN_LEN - 1);

    logic [PW-1:0]    div_cnt;
    logic [WIN_W-1:0] win_cnt;
    logic             stretch;
    logic [PW-1:0]    end_val;
    logic             hit;

    // Terminal pulse index for the current second, stretched when owed.
    always_comb begin
        stretch  = (win_cnt < frac);
        end_val  = {1'b0, div_last} + PW'(stretch);
        hit      = osc_tick && (div_cnt >= end_val);
        sec_tick = hit && !restart;
    end

    // Advance the pulse counter and the window index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
            win_cnt <= '0;
        end else if (restart) begin
            div_cnt <= '0;
        end else if (osc_tick) begin
            if (hit) begin
                div_cnt <= '0;
                win_cnt <= (win_cnt == WIN_END) ? '0 : win_cnt + 1'b1;
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end
    end

    p_win_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        win_cnt <= WIN_END);
    p_idle_no_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_tick |-> !sec_tick);
    p_restart_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> div_cnt == '0);
endmodule

// File: rtl/rtc_flags.sv
// Sticky status flags, one per lane. A flag sets on set[i] and clears on
// clr[i]. When both arrive in one cycle, the set wins.
module rtc_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flag
);
    for (genvar i = 0; i < N; i++) begin : g_lane
        // Hold one flag, with set taking priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)      flag[i] <= 1'b0;
            else if (set[i]) flag[i] <= 1'b1;
            else if (clr[i]) flag[i] <= 1'b0;
        end

        p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> flag[i]);
        p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !set[i]) |=> !flag[i]);
    end
endmodule

// File: rtl/rtc_core.sv
// Real-time clock top. It holds the register file (alarm, count, trim, status),
// the seconds counter and the alarm compare. It also instantiates the trimmed
// divider and the flag bank. Assumes a single-cycle write strobe and a
// combinational read.
module rtc_core
    import rtc_pkg::*;
#(
    parameter int DIV_W   = 16,
    parameter int WIN_W   = 10,
    parameter int WIN_LEN = 1023,
    parameter int DIV_RST = 32767
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [DATA_W-1:0] seconds;
    logic [DATA_W-1:0] alarm_q;
    logic [DIV_W-1:0]  trim_int;
    logic [WIN_W-1:0]  trim_frac;
    logic              alm_en, tck_en;
    logic              wr_alarm, wr_count, wr_trim, wr_stat;
    logic              sec_tick;
    logic [1:0]        flag_set, flag_clr, flags;

    // Decode which register a write targets.
    always_comb begin
        wr_alarm = bus_wr && (bus_addr == OFF_ALARM);
        wr_count = bus_wr && (bus_addr == OFF_COUNT);
        wr_trim  = bus_wr && (bus_addr == OFF_TRIM);
        wr_stat  = bus_wr && (bus_addr == OFF_STAT);
    end

    rtc_prescaler #(.DIV_W(DIV_W), .WIN_W(WIN_W), .WIN_LEN(WIN_LEN)) i_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_tick (osc_tick),
        .restart  (wr_count),
        .div_last (trim_int),
        .frac     (trim_frac),
        .sec_tick (sec_tick)
    );

    // Seconds counter: a load wins over an increment.
    always_ff @(posedge clk) begin
        if (!rst_n)        seconds <= '0;
        else if (wr_count) seconds <= bus_wdata;
        else if (sec_tick) seconds <= seconds + 1'b1;
    end

    // Software-written configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q   <= '0;
            trim_int  <= DIV_W'(DIV_RST);
            trim_frac <= '0;
            alm_en    <= 1'b0;
            tck_en    <= 1'b0;
        end else begin
            if (wr_alarm) alarm_q <= bus_wdata;
            if (wr_trim) begin
                trim_int  <= bus_wdata[DIV_W-1:0];
                trim_frac <= bus_wdata[DIV_W +: WIN_W];
            end
            if (wr_stat) begin
                alm_en <= bus_wdata[ST_ALM_EN];
                tck_en <= bus_wdata[ST_TCK_EN];
            end
        end
    end

    // Flag set sources (boundary events) and write-1 clears.
    always_comb begin
        flag_set[0] = sec_tick && alm_en && ((seconds + 1'b1) == alarm_q);
        flag_set[1] = sec_tick;
        flag_clr[0] = wr_stat && bus_wdata[ST_ALM_FLAG];
        flag_clr[1] = wr_stat && bus_wdata[ST_TCK_FLAG];
    end

    rtc_flags #(.N(2)) i_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_set),
        .clr   (flag_clr),
        .flag  (flags)
    );

    // Read multiplexer; unmapped offsets return zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_ALARM: bus_rdata = alarm_q;
            OFF_COUNT: bus_rdata = seconds;
            OFF_TRIM: begin
                bus_rdata[DIV_W-1:0]     = trim_int;
                bus_rdata[DIV_W +: WIN_W] = trim_frac;
            end
            OFF_STAT: begin
                bus_rdata[ST_ALM_FLAG] = flags[0];
                bus_rdata[ST_TCK_FLAG] = flags[1];
                bus_rdata[ST_ALM_EN]   = alm_en;
                bus_rdata[ST_TCK_EN]   = tck_en;
            end
            default: bus_rdata = '0;
        endcase
    end

    // Interrupt combines the alarm flag with the gated tick flag.
    always_comb irq = flags[0] || (flags[1] && tck_en);

    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !wr_count) |=> seconds == $past(seconds) + 1'b1);
    p_count_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_tick && !wr_count) |=> $stable(seconds));
    p_load_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_count |=> seconds == $past(bus_wdata));
    p_alarm_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!alm_en && !flags[0]) |=> !flags[0]);
endmodule

// File: tb/test_rtc_core.sv
module test_rtc_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_tick = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    rtc_core i_rtc_core (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // called at a negedge; the write lands on the next posedge, returns at the following negedge
    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_wr = 1'b0; osc_tick = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic int exp_cycles(input int l, input int f, input int n);
        int t = 0;
        for (int s = 0; s < n; s++) t += l + 1 + (((s % 1023) < f) ? 1 : 0);
        return t;
    endfunction

    // {integer trim, fraction, seconds to run}
    localparam logic [47:0] VEC [6] = '{
        {16'd3, 16'd0,    16'd5},
        {16'd3, 16'd2,    16'd5},
        {16'd7, 16'd1022, 16'd4},
        {16'd2, 16'd1023, 16'd6},
        {16'd0, 16'd1,    16'd1025},
        {16'd5, 16'd0,    16'd3}
    };

    initial begin
        logic [31:0] d;
        int t;

        // R1 reset state
        do_reset();
        bus_read(5'h04, d); chk("R1 count", d, 32'h0);
        bus_read(5'h00, d); chk("R1 alarm", d, 32'h0);
        bus_read(5'h08, d); chk("R1 trim", d, 32'h0000_7FFF);
        bus_read(5'h10, d); chk("R1 status", d, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // vector walk: R2 integer period, R3 fraction and window wrap, R8 tick flag
        foreach (VEC[i]) begin
            int l, f, n;
            l = int'(VEC[i][47:32]); f = int'(VEC[i][31:16]); n = int'(VEC[i][15:0]);
            do_reset();
            bus_write(5'h08, {6'b0, f[9:0], l[15:0]});
            bus_write(5'h04, 32'h0);
            t = exp_cycles(l, f, n);
            repeat (t - 1) @(negedge clk);
            bus_read(5'h04, d); chk("R2/R3 count before last boundary", d, 32'(n - 1));
            @(negedge clk);
            bus_read(5'h04, d); chk("R2/R3 count at boundary", d, 32'(n));
            bus_read(5'h10, d); chk("R8 tick flag", d & 32'h2, 32'h2);
        end

        // R6 readback and unmapped offset
        do_reset();
        bus_write(5'h00, 32'hCAFE_0123);
        bus_write(5'h08, 32'h0155_0009);
        bus_read(5'h00, d); chk("R6 alarm readback", d, 32'hCAFE_0123);
        bus_read(5'h08, d); chk("R6 trim readback", d, 32'h0155_0009);
        bus_read(5'h0C, d); chk("R6 unmapped read", d, 32'h0);

        // R5 load collides with a boundary (period 4)
        do_reset();
        bus_write(5'h08, 32'h3);
        bus_write(5'h04, 32'd10);
        repeat (3) @(negedge clk);
        bus_write(5'h04, 32'd100);
        bus_read(5'h04, d); chk("R5 load wins over boundary", d, 32'd100);
        repeat (3) @(negedge clk);
        bus_read(5'h04, d); chk("R5 full second after load", d, 32'd100);
        @(negedge clk);
        bus_read(5'h04, d); chk("R5 increment after full second", d, 32'd101);

        // R4 stall while osc_tick low
        osc_tick = 1'b0;
        repeat (40) @(negedge clk);
        bus_read(5'h04, d); chk("R4 count frozen", d, 32'd101);
        osc_tick = 1'b1;

        // R7/R9/R10 alarm set colliding with write-1 clear (period 2, alarm 3)
        do_reset();
        bus_write(5'h08, 32'h1);
        bus_write(5'h10, 32'h4);
        bus_write(5'h00, 32'd3);
        bus_write(5'h04, 32'd0);
        repeat (5) @(negedge clk);
        bus_write(5'h10, 32'h5);
        bus_read(5'h10, d); chk("R9 set wins over clear / R7 alarm", d, 32'h7);
        chk("R10 irq from alarm", {31'b0, irq}, 32'h1);
        bus_write(5'h10, 32'h5);
        bus_read(5'h10, d); chk("R9 w1c alarm clear", d, 32'h6);
        chk("R10 irq gated tick", {31'b0, irq}, 32'h0);
        bus_write(5'h10, 32'hC);
        bus_read(5'h10, d); chk("R10 tick enable", d & 32'hA, 32'hA);
        chk("R10 irq from tick", {31'b0, irq}, 32'h1);
        bus_write(5'h10, 32'h2);
        bus_read(5'h10, d); chk("R9 w1c tick clear", d, 32'h0);

        // R7 alarm disabled: reaching the alarm value leaves bit 0 clear
        bus_write(5'h00, 32'd50);
        bus_write(5'h04, 32'd48);
        repeat (6) @(negedge clk);
        bus_read(5'h04, d); chk("R7 count passed alarm", d, 32'd51);
        bus_read(5'h10, d); chk("R7 no alarm when disabled", d & 32'h1, 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule